// File: doc/BRIEF.md
# Serial-In Latched LED Output Register

This block is the digital front end of an eight-channel sink driver for common-anode LEDs. A host moves channel data in one bit at a time, using a serial data line and a serial clock. It then copies the loaded word into an output latch. An active-low output enable decides whether each latched bit actually turns its channel on. A serial output repeats the last stage of the shift register, so several devices can share one clock, latch and enable and be chained through their data lines.

The block runs on a fast system clock. The serial clock, serial data, latch and enable pins are brought in through synchronizer stages. A two-state phase tracker watches the synchronized serial clock. It is in `PH_LOW` or `PH_HIGH`. The `RISE` transition (`PH_LOW` to `PH_HIGH`) raises a shift strobe. The `FALL` transition (`PH_HIGH` to `PH_LOW`) raises a retime strobe for the serial output. Every other cycle is a hold transition that leaves the state unchanged.

The latch follows the shift register while the latch pin is high and freezes while it is low. An over-temperature flag is a synchronous input that forces all channels off, even when the enable is asserted, and leaves all stored data intact. The analog current sinks are not part of this block.

Top module: `serial_led_register`

## Requirements
- R1: An active-high asynchronous reset clears the shift register, the latch, the serial output and all channel outputs. After reset all channels are off and the serial output is 0. Opening the latch with no new data still shows all channels off.
- R2: On each rising edge of the serial clock, the serial data bit enters shift stage 0 and every stage k moves to stage k+1. Channel k therefore carries the bit shifted in k serial clocks earlier. A byte sent most significant bit first lands with bit k on channel k.
- R3: The serial output equals the last shift stage (stage 7). It changes only after a falling edge of the serial clock. Between a rising edge and the following falling edge it keeps its previous value.
- R4: While the latch input is high, the latch follows the shift register contents. The channel outputs track each shifted bit.
- R5: While the latch input is low, the latch holds its value. Shifting new data then leaves the channel outputs unchanged.
- R6: With enable low (0), channel k is on (1) exactly when latched bit k is 1. With enable high (1), all channels are off (0).
- R7: Enable does not alter stored data or the serial path. Data shifted and latched while enable is high appears on the channels once enable returns low.
- R8: The over-temperature input at 1 forces all channels off even when enable is low. It keeps the latch contents, so the previous pattern reappears when it returns to 0.
- R9: With two devices chained (serial output of the first driving serial data of the second), sixteen bits sent most significant bit first leave the first byte in the second device and the second byte in the first device after one latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous to clk |
| sdata_in | input | 1 | Serial data bit |
| latch_in | input | 1 | Latch control: 1 transparent, 0 hold |
| oe_n_in | input | 1 | Active-low output enable |
| otemp_in | input | 1 | Over-temperature force-off, synchronous to clk |
| sout_o | output | 1 | Cascade serial output, retimed on serial clock falling edges |
| chan_on_o | output | NCH | Channel on/off controls, 1 = sink on |

## Verification
The shift path is checked with a partial nibble followed by a full byte while the latch is open. This separates the bit order toward channel 7 from a reversed or whole-word load. The bytes A5, 3C, 81 and two chained bytes 6E/17 use asymmetric patterns, so a swapped channel or a stage skipped in the chain shows as a wrong value. The serial output is sampled between a rising and a falling serial edge, which tells falling-edge retiming apart from a plain copy of the last stage. Shifting with the latch closed, with enable high and with over-temperature set shows whether the hold and force-off paths also corrupt the stored word.

// File: rtl/sled_pkg.sv
package sled_pkg;
    typedef enum logic [0:0] {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } sclk_phase_e;
endpackage

// File: rtl/sled_sync.sv
module sled_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sled_edge_fsm.sv
module sled_edge_fsm
    import sled_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    output logic rise_o,
    output logic fall_o
);
    sclk_phase_e state_q, state_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= PH_LOW;
        else     state_q <= state_d;
    end

    // next state: RISE, FALL or hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (sclk_s)  state_d = PH_HIGH;
            PH_HIGH: if (!sclk_s) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    // strobes
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            PH_LOW:  rise_o = sclk_s;
            PH_HIGH: fall_o = !sclk_s;
            default: ;
        endcase
    end
endmodule

// File: rtl/sled_shift.sv
module sled_shift #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           sdata,
    input  logic           retime_en,
    output logic [NCH-1:0] sr_o,
    output logic           sout_o
);
    logic [NCH-1:0] sr_q;
    logic           sout_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[NCH-2:0], sdata};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)            sout_q <= 1'b0;
        else if (retime_en) sout_q <= sr_q[NCH-1];
    end

    assign sr_o   = sr_q;
    assign sout_o = sout_q;

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (sr_q[NCH-1:1] == $past(sr_q[NCH-2:0])) && (sr_q[0] == $past(sdata)));

    // R3
    sout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !retime_en |=> $stable(sout_q));

    // R3
    sout_last_chk: assert property (@(posedge clk) disable iff (rst)
        retime_en |=> sout_q == $past(sr_q[NCH-1]));
endmodule

// File: rtl/sled_latch_gate.sv
module sled_latch_gate #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           open_en,
    input  logic [NCH-1:0] sr_i,
    input  logic           oe_n,
    input  logic           otemp,
    output logic [NCH-1:0] ch_o
);
    logic [NCH-1:0] lat_q;
    logic [NCH-1:0] ch_q;
    logic           force_off;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)          lat_q <= '0;
        else if (open_en) lat_q <= sr_i;
    end

    assign force_off = oe_n | otemp;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ch_q <= '0;
        else     ch_q <= force_off ? '0 : lat_q;
    end

    assign ch_o = ch_q;

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !open_en |=> $stable(lat_q));

    // R6
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |=> ch_q == '0);

    // R8
    otemp_off_chk: assert property (@(posedge clk) disable iff (rst)
        otemp |=> ch_q == '0);

    // R4
    latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
        open_en |=> lat_q == $past(sr_i));
endmodule

// File: rtl/serial_led_register.sv
module serial_led_register #(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk_in,
    input  logic           sdata_in,
    input  logic           latch_in,
    input  logic           oe_n_in,
    input  logic           otemp_in,
    output logic           sout_o,
    output logic [NCH-1:0] chan_on_o
);
    localparam int SYNC_W = 4;

    logic [SYNC_W-1:0] pins_raw, pins_s;
    logic              sclk_s, sdata_s, latch_s, oe_n_s;
    logic              rise, fall;
    logic [NCH-1:0]    sr;

    assign pins_raw = {oe_n_in, latch_in, sdata_in, sclk_in};

    sled_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign sclk_s  = pins_s[0];
    assign sdata_s = pins_s[1];
    assign latch_s = pins_s[2];
    assign oe_n_s  = pins_s[3];

    sled_edge_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (sclk_s),
        .rise_o (rise),
        .fall_o (fall)
    );

    sled_shift #(.NCH(NCH)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (rise),
        .sdata     (sdata_s),
        .retime_en (fall),
        .sr_o      (sr),
        .sout_o    (sout_o)
    );

    sled_latch_gate #(.NCH(NCH)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .open_en (latch_s),
        .sr_i    (sr),
        .oe_n    (oe_n_s),
        .otemp   (otemp_in),
        .ch_o    (chan_on_o)
    );

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise && fall));
endmodule

// File: tb/serial_led_register_tb_top.sv
module serial_led_register_tb_top;
    localparam int PH = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       sclk = 1'b0, sdata = 1'b0, latch = 1'b0, oe_n = 1'b0, otemp = 1'b0;
    logic       sout_a, sout_b;
    logic [7:0] ch_a, ch_b;
    logic [7:0] sr_m;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    serial_led_register dut_i (
        .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sdata), .latch_in(latch),
        .oe_n_in(oe_n), .otemp_in(otemp), .sout_o(sout_a), .chan_on_o(ch_a)
    );

    serial_led_register dut_nxt_i (
        .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sout_a), .latch_in(latch),
        .oe_n_in(oe_n), .otemp_in(otemp), .sout_o(sout_b), .chan_on_o(ch_b)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata = b;
        repeat (PH) @(negedge clk);
        sclk = 1'b1;
        repeat (PH) @(negedge clk);
        sclk = 1'b0;
        sr_m = {sr_m[6:0], b};
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_latch();
        latch = 1'b1;
        settle();
        latch = 1'b0;
        settle();
    endtask

    task automatic do_reset();
        rst = 1'b1; sclk = 1'b0; sdata = 1'b0; latch = 1'b0; oe_n = 1'b0; otemp = 1'b0;
        sr_m = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 channels off after reset", ch_a, 8'h00);
        check("R1 serial out low after reset", {7'd0, sout_a}, 8'h00);
        latch = 1'b1;
        settle();
        check("R1 cleared latch source", ch_a, 8'h00);
        latch = 1'b0;
        settle();
    endtask

    task automatic t_shift();
        do_reset();
        latch = 1'b1;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        settle();
        check("R4 transparent partial nibble", ch_a, sr_m);
        check("R2 nibble order", ch_a, 8'h0B);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        settle();
        check("R2 full byte order", ch_a, 8'hB5);
        send_byte(8'hA5);
        settle();
        check("R4 follows byte A5", ch_a, 8'hA5);
        latch = 1'b0;
        settle();
    endtask

    task automatic t_hold();
        send_byte(8'h3C);
        settle();
        check("R5 hold during shift", ch_a, 8'hA5);
        pulse_latch();
        check("R5 new byte after latch pulse", ch_a, 8'h3C);
    endtask

    task automatic t_enable();
        oe_n = 1'b1;
        settle();
        check("R6 enable high forces off", ch_a, 8'h00);
        send_byte(8'h81);
        pulse_latch();
        check("R6 still off after load", ch_a, 8'h00);
        oe_n = 1'b0;
        settle();
        check("R7 data loaded while disabled", ch_a, 8'h81);
        oe_n = 1'b1;
        settle();
        oe_n = 1'b0;
        settle();
        check("R7 pattern kept across disable", ch_a, 8'h81);
    endtask

    task automatic t_otemp();
        otemp = 1'b1;
        settle();
        check("R8 overtemp overrides enable", ch_a, 8'h00);
        otemp = 1'b0;
        settle();
        check("R8 pattern returns", ch_a, 8'h81);
    endtask

    task automatic t_sout();
        do_reset();
        send_bit(1'b1);
        for (int i = 0; i < 6; i++) send_bit(1'b0);
        settle();
        check("R3 last stage still zero", {7'd0, sout_a}, 8'h00);
        sdata = 1'b0;
        repeat (PH) @(negedge clk);
        sclk = 1'b1;
        repeat (PH) @(negedge clk);
        check("R3 no change before falling edge", {7'd0, sout_a}, 8'h00);
        sclk = 1'b0;
        sr_m = {sr_m[6:0], 1'b0};
        settle();
        check("R3 update after falling edge", {7'd0, sout_a}, {7'd0, sr_m[7]});
    endtask

    task automatic t_cascade();
        do_reset();
        send_byte(8'h6E);
        send_byte(8'h17);
        settle();
        check("R5 chain hold before latch first", ch_a, 8'h00);
        check("R5 chain hold before latch second", ch_b, 8'h00);
        pulse_latch();
        check("R9 first device gets later byte", ch_a, 8'h17);
        check("R9 second device gets earlier byte", ch_b, 8'h6E);
    endtask

    initial begin
        t_reset();
        t_shift();
        t_hold();
        t_enable();
        t_otemp();
        t_sout();
        t_cascade();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule